// File: doc/BRIEF.md
# Cassette Tape Controller Register and Status Interface

This block is the host-facing register file of a cassette tape controller. A byte-wide bus with a one-bit address reaches three registers. Address 0 is the control register when written and the status register when read. Address 1 is the data register in both directions. The control byte is presented to the motion sequencer. The data byte is shared with the bit-serial data path, which can also load a received byte into it.

The status byte is built at the moment of each read. Some of its bits are sticky flags held in the block: cassette present, hole seen, tachometer tick seen and ready. Others come from live drive inputs: stall, overcurrent, write protect, cartridge out and minimum gap reached. The command state reported by the sequencer overrides some bits. Every status read returns the composed byte and then clears the event flags, so software sees each event once.

Top module: `tape_reg_if`

## Requirements
- R1: A synchronous active-high reset clears the control register, the data register, all sticky flags and the read data output to zero.
- R2: A write to address 0 loads the control register (output `ctrl_q`). A write to address 1 loads the data register (output `data_q`). Any read places its result on `bus_rdata` in the cycle after the read strobe. A read of address 1 returns the data register.
- R3: A rising edge on `hole_pulse` sets status bit 4, and a rising edge on `tach_pulse` sets status bit 6. Each bit stays set until the next status read.
- R4: A status read returns the composed byte, then clears the hole, tach and ready flags. An edge that arrives in the same cycle as the read is not lost: it is absent from that read and shows on the next one.
- R5: Status bit 0 (cassette in) is cleared whenever `cart_out` is high. It becomes 1 again only after a status read made while `cart_out` is low, so that read returns 0 and later reads return 1.
- R6: With the sequencer state encoded as 0 idle, 1 starting, 2 stopping, 3 plain move, 4 read-sync, 5 reading, 6 writing and 7 gap erase, status bit 7 (ready) reads as 1 in state 0 and as 0 in states 2, 3 and 7. In all other states it reads as the sticky ready flag.
- R7: Status bit 3 (write enabled) reads as 1 exactly when control bit 6 (write sync) or control bit 7 (write gap) is set, and either `cart_out` is high or `wr_protect` is low.
- R8: Status bit 5 (gap) reads as 1 exactly when the sequencer is idle or `gap_reached` is high.
- R9: Status bit 1 (stall) and status bit 2 (overcurrent) follow `stall` and `overcur` at the moment of the read, without latching.
- R10: A pulse on `rdy_set` sets the sticky ready flag. `dp_load` loads `dp_byte` into the data register unless a host write to address 1 occurs in the same cycle, in which case the host value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | 1 | Register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| ctrl_q | output | 8 | Control register to the sequencer |
| data_q | output | 8 | Data register to the data path |
| seq_state | input | 3 | Sequencer command state |
| rdy_set | input | 1 | Sets the ready flag |
| dp_load | input | 1 | Data path byte load strobe |
| dp_byte | input | 8 | Byte from the data path |
| cart_out | input | 1 | Cartridge absent |
| wr_protect | input | 1 | Write protect active |
| hole_pulse | input | 1 | Hole detector |
| tach_pulse | input | 1 | Tachometer tick |
| gap_reached | input | 1 | Minimum gap length reached |
| stall | input | 1 | Tape stalled |
| overcur | input | 1 | Motor overcurrent |

## Verification
On every cycle, the assertions check that sticky flags hold between reads, that a read clears them, that cassette-in drops while the cartridge is out, that an idle read reports ready, and that write-enabled reads 0 when neither write control bit is set. Other behaviours can only be shown by the bench's scenarios. These are the sweep of every sequencer state against the gap and live fault inputs, the full control byte sweep against cartridge and protect inputs, the exact read on which cassette-in reappears, and an edge that coincides with a read.

// File: rtl/tape_reg_pkg.sv
package tape_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEQ_W  = 3;

  // status bit positions
  localparam int unsigned ST_CASS  = 0;
  localparam int unsigned ST_STALL = 1;
  localparam int unsigned ST_OVC   = 2;
  localparam int unsigned ST_WEN   = 3;
  localparam int unsigned ST_HOLE  = 4;
  localparam int unsigned ST_GAP   = 5;
  localparam int unsigned ST_TACH  = 6;
  localparam int unsigned ST_RDY   = 7;

  // control bit positions used here
  localparam int unsigned CT_WSYNC = 6;
  localparam int unsigned CT_WGAP  = 7;

  typedef enum logic [SEQ_W-1:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_START  = 3'd1,
    SEQ_STOP   = 3'd2,
    SEQ_MOVE   = 3'd3,
    SEQ_RDSYNC = 3'd4,
    SEQ_READ   = 3'd5,
    SEQ_WRITE  = 3'd6,
    SEQ_ERASE  = 3'd7
  } seq_e;

  typedef struct packed {
    logic rdy;
    logic tach;
    logic hole;
    logic cass;
  } flags_t;
endpackage

// File: rtl/tape_edge_det.sv
module tape_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/tape_status_flags.sv
module tape_status_flags
  import tape_reg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   rd_stat,
  input  logic   cart_out,
  input  logic   hole_rise,
  input  logic   tach_rise,
  input  logic   rdy_set,
  output flags_t flags
);
  flags_t f_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q <= '0;
    end else begin
      if (hole_rise)    f_q.hole <= 1'b1;
      else if (rd_stat) f_q.hole <= 1'b0;

      if (tach_rise)    f_q.tach <= 1'b1;
      else if (rd_stat) f_q.tach <= 1'b0;

      if (rdy_set)      f_q.rdy <= 1'b1;
      else if (rd_stat) f_q.rdy <= 1'b0;

      if (cart_out)     f_q.cass <= 1'b0;
      else if (rd_stat) f_q.cass <= 1'b1;
    end
  end

  assign flags = f_q;

  p_hole_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (f_q.hole && !rd_stat) |=> f_q.hole);
  p_tach_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (f_q.tach && !rd_stat) |=> f_q.tach);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !hole_rise) |=> !f_q.hole);
  p_cass_drop_r5: assert property (@(posedge clk) disable iff (rst)
    cart_out |=> !f_q.cass);
endmodule

// File: rtl/tape_status_compose.sv
module tape_status_compose
  import tape_reg_pkg::*;
(
  input  flags_t            flags,
  input  logic [SEQ_W-1:0]  seq_state,
  input  logic              wsync,
  input  logic              wgap,
  input  logic              cart_out,
  input  logic              wr_protect,
  input  logic              gap_reached,
  input  logic              stall,
  input  logic              overcur,
  output logic [BYTE_W-1:0] status
);
  seq_e st;
  logic is_idle, force_low;

  always_comb begin
    st        = seq_e'(seq_state);
    is_idle   = (st == SEQ_IDLE);
    force_low = (st == SEQ_STOP) || (st == SEQ_MOVE) || (st == SEQ_ERASE);

    status           = '0;
    status[ST_CASS]  = flags.cass;
    status[ST_STALL] = stall;
    status[ST_OVC]   = overcur;
    status[ST_WEN]   = (wsync | wgap) & (cart_out | ~wr_protect);
    status[ST_HOLE]  = flags.hole;
    status[ST_GAP]   = is_idle | gap_reached;
    status[ST_TACH]  = flags.tach;
    if (is_idle)        status[ST_RDY] = 1'b1;
    else if (force_low) status[ST_RDY] = 1'b0;
    else                status[ST_RDY] = flags.rdy;
  end
endmodule

// File: rtl/tape_reg_if.sv
module tape_reg_if
  import tape_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] data_q,
  input  logic [SEQ_W-1:0]  seq_state,
  input  logic              rdy_set,
  input  logic              dp_load,
  input  logic [BYTE_W-1:0] dp_byte,
  input  logic              cart_out,
  input  logic              wr_protect,
  input  logic              hole_pulse,
  input  logic              tach_pulse,
  input  logic              gap_reached,
  input  logic              stall,
  input  logic              overcur
);
  localparam int unsigned NPULSE = 2;

  logic              rd_stat, rd_data, wr_ctrl, wr_data;
  logic [NPULSE-1:0] rises;
  flags_t            flags;
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-1:0] ctrl_r, data_r, rdata_r;

  assign rd_stat = bus_re & ~bus_addr;
  assign rd_data = bus_re &  bus_addr;
  assign wr_ctrl = bus_we & ~bus_addr;
  assign wr_data = bus_we &  bus_addr;

  tape_edge_det #(.N(NPULSE)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({tach_pulse, hole_pulse}),
    .rise (rises)
  );

  tape_status_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .rd_stat   (rd_stat),
    .cart_out  (cart_out),
    .hole_rise (rises[0]),
    .tach_rise (rises[1]),
    .rdy_set   (rdy_set),
    .flags     (flags)
  );

  tape_status_compose u_comp (
    .flags       (flags),
    .seq_state   (seq_state),
    .wsync       (ctrl_r[CT_WSYNC]),
    .wgap        (ctrl_r[CT_WGAP]),
    .cart_out    (cart_out),
    .wr_protect  (wr_protect),
    .gap_reached (gap_reached),
    .stall       (stall),
    .overcur     (overcur),
    .status      (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r  <= '0;
      data_r  <= '0;
      rdata_r <= '0;
    end else begin
      if (wr_ctrl) ctrl_r <= bus_wdata;
      if (wr_data)      data_r <= bus_wdata;
      else if (dp_load) data_r <= dp_byte;
      if (rd_stat)      rdata_r <= status;
      else if (rd_data) rdata_r <= data_r;
    end
  end

  assign ctrl_q    = ctrl_r;
  assign data_q    = data_r;
  assign bus_rdata = rdata_r;

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (ctrl_q == $past(bus_wdata)));
  p_idle_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && seq_state == SEQ_IDLE) |=> bus_rdata[ST_RDY]);
  p_wen_off_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !ctrl_q[CT_WSYNC] && !ctrl_q[CT_WGAP]) |=> !bus_rdata[ST_WEN]);
  p_gap_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && (seq_state == SEQ_IDLE || gap_reached)) |=> bus_rdata[ST_GAP]);
endmodule

// File: tb/tb_tape_reg_if.sv
module tb_tape_reg_if;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 0, bus_re = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, ctrl_q, data_q;
  logic [2:0] seq_state = 0;
  logic       rdy_set = 0, dp_load = 0;
  logic [7:0] dp_byte = 0;
  logic       cart_out = 0, wr_protect = 0, hole_pulse = 0, tach_pulse = 0;
  logic       gap_reached = 0, stall = 0, overcur = 0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  tape_reg_if dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic pulse_rdy();
    @(negedge clk); rdy_set = 1;
    @(negedge clk); rdy_set = 0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(bus_rdata == 0 && ctrl_q == 0 && data_q == 0, "R1", {bus_rdata, ctrl_q, data_q}, 0);
    seq_state = 3'd1;
    rd(0, v);
    check(v == 8'h00, "R1 status after reset", v, 8'h00);
    // R5: that read set cassette-in
    rd(0, v);
    check(v[0] == 1, "R5 cass after read", v[0], 1);
    @(negedge clk); cart_out = 1;
    @(negedge clk); cart_out = 0;
    rd(0, v);
    check(v[0] == 0, "R5 cleared by cart_out", v[0], 0);
    rd(0, v);
    check(v[0] == 1, "R5 reappears", v[0], 1);

    // R2 control and data registers, full sweep
    for (int c = 0; c < 256; c++) begin
      wr(0, 8'(c));
      check(ctrl_q == 8'(c), "R2 ctrl", ctrl_q, c);
      wr(1, 8'(255 - c));
      check(data_q == 8'(255 - c), "R2 data", data_q, 255 - c);
      rd(1, v);
      check(v == 8'(255 - c), "R2 data read", v, 255 - c);
      // R7 write-enable sweep
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); cart_out = k[1]; wr_protect = k[0];
        rd(0, v);
        check(v[3] == ((c[6] | c[7]) & (k[1] | ~k[0])), "R7 wen", v[3], (c[6] | c[7]) & (k[1] | ~k[0]));
      end
    end
    @(negedge clk); cart_out = 0; wr_protect = 0;
    wr(0, 8'h00);
    rd(0, v);

    // R6 R8 R9 sweep over states and live inputs
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 8; m++) begin
        logic [7:0] e;
        @(negedge clk); seq_state = 3'(s); gap_reached = m[0]; stall = m[1]; overcur = m[2];
        pulse_rdy();
        rd(0, v);
        e = {(s == 0) ? 1'b1 : (s == 2 || s == 3 || s == 7) ? 1'b0 : 1'b1,
             1'b0, (s == 0) | m[0], 1'b0, 1'b0, m[2], m[1], 1'b1};
        check(v == e, "R6 R8 R9 status", v, e);
        rd(0, v);
        e[7] = (s == 0);
        check(v == e, "R6 R4 ready cleared", v, e);
      end
    end
    @(negedge clk); seq_state = 3'd5; gap_reached = 0; stall = 0; overcur = 0;

    // R3 sticky hole and tach
    @(negedge clk); hole_pulse = 1;
    @(negedge clk); hole_pulse = 0;
    repeat (5) @(negedge clk);
    @(negedge clk); tach_pulse = 1;
    repeat (3) @(negedge clk);
    tach_pulse = 0;
    rd(0, v);
    check(v[4] == 1 && v[6] == 1, "R3 sticky", {v[6], v[4]}, 2'b11);
    rd(0, v);
    check(v[4] == 0 && v[6] == 0, "R4 cleared", {v[6], v[4]}, 0);
    // R3 held level gives no new edge
    @(negedge clk); hole_pulse = 1;
    rd(0, v);
    rd(0, v);
    check(v[4] == 0, "R3 level no re-set", v[4], 0);
    @(negedge clk); hole_pulse = 0;

    // R4 edge coincident with read
    @(negedge clk); bus_re = 1; bus_addr = 0; tach_pulse = 1;
    @(negedge clk); bus_re = 0; tach_pulse = 0; v = bus_rdata;
    check(v[6] == 0, "R4 coincident absent", v[6], 0);
    rd(0, v);
    check(v[6] == 1, "R4 coincident kept", v[6], 1);

    // R10 data path load and priority
    @(negedge clk); dp_load = 1; dp_byte = 8'h5A;
    @(negedge clk); dp_load = 0;
    check(data_q == 8'h5A, "R10 dp load", data_q, 8'h5A);
    @(negedge clk); dp_load = 1; dp_byte = 8'h11; bus_we = 1; bus_addr = 1; bus_wdata = 8'hC3;
    @(negedge clk); dp_load = 0; bus_we = 0;
    check(data_q == 8'hC3, "R10 host wins", data_q, 8'hC3);
    pulse_rdy();
    rd(0, v);
    check(v[7] == 1, "R10 rdy_set", v[7], 1);

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check(ctrl_q == 0 && data_q == 0 && bus_rdata == 0, "R1 re-reset", {ctrl_q, data_q, bus_rdata}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule